// File: doc/BRIEF.md
# Power Management Event Status Aggregator

This block gathers power-management events into sticky status registers that software clears by writing ones, and drives one level-sensitive interrupt toward the system controller. Sixteen general-purpose event lines each set their own status bit. Separate set inputs feed a PM status register and a global status register. A device status register is loaded from software with the inverse of the written word. A register file in front of the block decodes addresses. It hands over an aligned register select, write data and a byte-lane mask, and it takes read data back one cycle later.

Reads of the global status register are assembled on the fly. The stored bits are merged with three summary flags that show whether PM status (ignoring its lowest bit), general-purpose status or device status currently hold anything. The interrupt is the OR of two gated pairs: PM status with resume enable, and general-purpose status with general-purpose enable. A legacy-mode request turns the interrupt-enable bit of the control register and bit 0 of resume enable on or off together.

Top module: `pmev_aggregator`

## Requirements
- R1: When event line n is high at a rising clock edge, general-purpose status bit n is 1 after that edge and stays 1 until software clears it.
- R2: A write to PM status (select 0) or general-purpose status (select 3) clears each bit that is 1 in the write data within an enabled byte lane. wr_be bit k enables data bits 8k+7..8k. All other bits keep their value.
- R3: A write to global status (select 5) clears only those written-1 bits that lie inside mask 0x0D25. Every stored bit outside that mask is unaffected.
- R4: A global status read returns the stored value ORed with three flags. Bit 6 is set when any PM status bit above bit 0 is set. Bit 7 is set when general-purpose status is nonzero. Bit 4 is set when device status is nonzero.
- R5: irq_o is 1 exactly when (resume enable is nonzero and PM status is nonzero) or (general-purpose status is nonzero and general-purpose enable is nonzero). It follows the register state at the same clock edge that updates that state.
- R6: A write to device status (select 6) loads the bitwise inverse of all DEV_W bits of wr_data and ignores wr_be.
- R7: A cycle with mode_req and mode_on high sets control bit 0 and resume-enable bit 0. A cycle with mode_req high and mode_on low clears both bits. Either action overrides a register write to the same bits in that cycle.
- R8: Resume enable (select 1) stores only the bits in 0x0521. General-purpose enable (select 4) stores only the bits in 0x0F01. Control (select 2) stores all 16 bits. Each of these registers changes only within enabled byte lanes.
- R9: If an event sets a status bit in the same cycle that a software write clears it, the bit ends up set.
- R10: A synchronous reset clears all status, enable and control registers, drives irq_o low and sets rd_data to zero.
- R11: rd_data shows, one clock after rd_sel is presented, the register selected by it as it stood before that edge. Select 7 reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_EVT | General-purpose event lines, level sensitive |
| pm_evt_i | input | REG_W | Set inputs for PM status bits |
| glb_evt_i | input | REG_W | Set inputs for global status bits |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write register select |
| wr_data | input | DEV_W | Write data |
| wr_be | input | DEV_W/8 | Write byte-lane mask |
| rd_sel | input | 3 | Read register select |
| rd_data | output | DEV_W | Registered read data |
| mode_req | input | 1 | Legacy-mode change strobe |
| mode_on | input | 1 | Legacy-mode target: 1 on, 0 off |
| irq_o | output | 1 | Level interrupt, registered |

## Verification
The bench uses the default parameters: 16 event lines, 16-bit status and enable registers, and a 32-bit device status register with four byte lanes. With these values the clear masks 0x0D25, 0x0521 and 0x0F01 apply in full. Partial-lane writes can leave the upper byte of a 16-bit register untouched. The device status word is wide enough to show that the byte mask is ignored there. Directed cases cover an event colliding with a clear, legacy-mode priority over a write, each interrupt pair on its own, and a mid-run reset.

// File: rtl/pmev_pkg.sv
package pmev_pkg;
  typedef enum logic [2:0] {
    SEL_PMSTS  = 3'd0,
    SEL_RSMEN  = 3'd1,
    SEL_CTRL   = 3'd2,
    SEL_GPSTS  = 3'd3,
    SEL_GPEN   = 3'd4,
    SEL_GLBSTS = 3'd5,
    SEL_DEVSTS = 3'd6,
    SEL_NONE   = 3'd7
  } pmev_sel_e;

  localparam int SEL_W       = 3;
  localparam int SUM_DEV_BIT = 4;
  localparam int SUM_PM_BIT  = 6;
  localparam int SUM_GP_BIT  = 7;
endpackage

// File: rtl/pmev_lane_mask.sv
module pmev_lane_mask #(
  parameter int NBYTES = 2
) (
  input  logic [NBYTES-1:0]   be,
  output logic [NBYTES*8-1:0] bits
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    assign bits[8*i +: 8] = {8{be[i]}};
  end
endmodule

// File: rtl/pmev_w1c_bank.sv
module pmev_w1c_bank #(
  parameter int           W        = 16,
  parameter logic [W-1:0] CLR_MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt_o
);
  // set dominates clear so a fresh event is never lost
  assign nxt_o = (q & ~(clr_i & CLR_MASK)) | set_i;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt_o;
  end

  AST_SET_STICKY: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((q & $past(set_i)) == $past(set_i)));  // R1
  AST_CLR_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    (clr_i != '0) |=> ((q & $past(clr_i & CLR_MASK & ~set_i)) == '0));  // R2
  AST_OUTSIDE_MASK_KEPT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(q) & ~CLR_MASK & ~q) == '0));  // R3
endmodule

// File: rtl/pmev_rw_reg.sv
module pmev_rw_reg #(
  parameter int           W         = 16,
  parameter logic [W-1:0] KEEP_MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] lane_bits,
  input  logic [W-1:0] force_set,
  input  logic [W-1:0] force_clr,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] after_wr;

  always_comb begin
    after_wr = q;
    if (wr_i) after_wr = (q & ~lane_bits) | (wdata & lane_bits & KEEP_MASK);
    nxt_o = (after_wr & ~force_clr) | force_set;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt_o;
  end

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((q & ~(KEEP_MASK | force_set)) == '0) |=> ((q & ~KEEP_MASK) == '0));  // R8
  AST_LANE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (force_set == '0 && force_clr == '0) |=>
      ((q & ~$past(wr_i ? lane_bits : '0)) == ($past(q) & ~$past(wr_i ? lane_bits : '0))));  // R8
endmodule

// File: rtl/pmev_aggregator.sv
module pmev_aggregator
  import pmev_pkg::*;
#(
  parameter int NUM_EVT = 16,
  parameter int REG_W   = 16,
  parameter int DEV_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [REG_W-1:0]   pm_evt_i,
  input  logic [REG_W-1:0]   glb_evt_i,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [DEV_W-1:0]   wr_data,
  input  logic [DEV_W/8-1:0] wr_be,
  input  logic [SEL_W-1:0]   rd_sel,
  output logic [DEV_W-1:0]   rd_data,
  input  logic               mode_req,
  input  logic               mode_on,
  output logic               irq_o
);
  localparam int REG_BYTES = REG_W / 8;
  localparam logic [REG_W-1:0] GLB_CLR  = REG_W'(16'h0D25);
  localparam logic [REG_W-1:0] RSM_KEEP = REG_W'(16'h0521);
  localparam logic [REG_W-1:0] GPE_KEEP = REG_W'(16'h0F01);
  localparam logic [REG_W-1:0] BIT0     = REG_W'(1);

  logic [REG_W-1:0] lanes;
  logic [REG_W-1:0] wdat;
  logic             wr_pm, wr_rsm, wr_ctl, wr_gp, wr_gpe, wr_glb, wr_dev;
  logic [REG_W-1:0] gp_set;
  logic [REG_W-1:0] mode_set, mode_clr;

  logic [REG_W-1:0] pm_q, pm_n, gp_q, gp_n, glb_q, glb_n;
  logic [REG_W-1:0] rsm_q, rsm_n, ctl_q, ctl_n, gpe_q, gpe_n;
  logic [DEV_W-1:0] dev_q;
  logic [REG_W-1:0] glb_view;
  logic [DEV_W-1:0] rd_n;
  logic             irq_q;

  pmev_lane_mask #(.NBYTES(REG_BYTES)) u_lanes (
    .be(wr_be[REG_BYTES-1:0]), .bits(lanes));

  assign wdat   = wr_data[REG_W-1:0];
  assign wr_pm  = wr_en && (wr_sel == SEL_PMSTS);
  assign wr_rsm = wr_en && (wr_sel == SEL_RSMEN);
  assign wr_ctl = wr_en && (wr_sel == SEL_CTRL);
  assign wr_gp  = wr_en && (wr_sel == SEL_GPSTS);
  assign wr_gpe = wr_en && (wr_sel == SEL_GPEN);
  assign wr_glb = wr_en && (wr_sel == SEL_GLBSTS);
  assign wr_dev = wr_en && (wr_sel == SEL_DEVSTS);

  always_comb begin
    gp_set = '0;
    gp_set[NUM_EVT-1:0] = evt_i;
  end

  assign mode_set = (mode_req &&  mode_on) ? BIT0 : '0;
  assign mode_clr = (mode_req && !mode_on) ? BIT0 : '0;

  pmev_w1c_bank #(.W(REG_W), .CLR_MASK('1)) u_pm (
    .clk(clk), .rst(rst), .set_i(pm_evt_i),
    .clr_i(wr_pm ? (wdat & lanes) : '0), .q(pm_q), .nxt_o(pm_n));

  pmev_w1c_bank #(.W(REG_W), .CLR_MASK('1)) u_gp (
    .clk(clk), .rst(rst), .set_i(gp_set),
    .clr_i(wr_gp ? (wdat & lanes) : '0), .q(gp_q), .nxt_o(gp_n));

  pmev_w1c_bank #(.W(REG_W), .CLR_MASK(GLB_CLR)) u_glb (
    .clk(clk), .rst(rst), .set_i(glb_evt_i),
    .clr_i(wr_glb ? (wdat & lanes) : '0), .q(glb_q), .nxt_o(glb_n));

  pmev_rw_reg #(.W(REG_W), .KEEP_MASK(RSM_KEEP)) u_rsm (
    .clk(clk), .rst(rst), .wr_i(wr_rsm), .wdata(wdat), .lane_bits(lanes),
    .force_set(mode_set), .force_clr(mode_clr), .q(rsm_q), .nxt_o(rsm_n));

  pmev_rw_reg #(.W(REG_W), .KEEP_MASK('1)) u_ctl (
    .clk(clk), .rst(rst), .wr_i(wr_ctl), .wdata(wdat), .lane_bits(lanes),
    .force_set(mode_set), .force_clr(mode_clr), .q(ctl_q), .nxt_o(ctl_n));

  pmev_rw_reg #(.W(REG_W), .KEEP_MASK(GPE_KEEP)) u_gpe (
    .clk(clk), .rst(rst), .wr_i(wr_gpe), .wdata(wdat), .lane_bits(lanes),
    .force_set('0), .force_clr('0), .q(gpe_q), .nxt_o(gpe_n));

  always_ff @(posedge clk) begin
    if (rst)         dev_q <= '0;
    else if (wr_dev) dev_q <= ~wr_data;
  end

  always_comb begin
    glb_view = glb_q;
    if (|pm_q[REG_W-1:1]) glb_view[SUM_PM_BIT]  = 1'b1;
    if (|gp_q)            glb_view[SUM_GP_BIT]  = 1'b1;
    if (|dev_q)           glb_view[SUM_DEV_BIT] = 1'b1;
  end

  always_comb begin
    case (pmev_sel_e'(rd_sel))
      SEL_PMSTS:  rd_n = DEV_W'(pm_q);
      SEL_RSMEN:  rd_n = DEV_W'(rsm_q);
      SEL_CTRL:   rd_n = DEV_W'(ctl_q);
      SEL_GPSTS:  rd_n = DEV_W'(gp_q);
      SEL_GPEN:   rd_n = DEV_W'(gpe_q);
      SEL_GLBSTS: rd_n = DEV_W'(glb_view);
      SEL_DEVSTS: rd_n = dev_q;
      default:    rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq_q   <= 1'b0;
    end else begin
      rd_data <= rd_n;
      irq_q   <= ((|rsm_n) && (|pm_n)) || ((|gp_n) && (|gpe_n));
    end
  end

  assign irq_o = irq_q;

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq_o == (((|rsm_q) && (|pm_q)) || ((|gp_q) && (|gpe_q))));  // R5
  AST_DEV_INVERT: assert property (@(posedge clk) disable iff (rst)
    wr_dev |=> (dev_q == ~$past(wr_data)));  // R6
  AST_MODE_ON: assert property (@(posedge clk) disable iff (rst)
    (mode_req && mode_on) |=> (ctl_q[0] && rsm_q[0]));  // R7
  AST_MODE_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode_req && !mode_on) |=> (!ctl_q[0] && !rsm_q[0]));  // R7
  AST_GP_SUMMARY: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == SEL_GLBSTS && gp_q != '0) |=> rd_data[SUM_GP_BIT]);  // R4
  AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((gp_q[NUM_EVT-1:0] & $past(evt_i)) == $past(evt_i)));  // R9
endmodule

// File: tb/sim_pmev_aggregator.sv
module sim_pmev_aggregator;
  localparam int NUM_EVT = 16;
  localparam int REG_W   = 16;
  localparam int DEV_W   = 32;

  // op: 0 write, 1 read-check, 2 gp event, 3 pm event, 4 global event
  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  sel;
    logic [31:0] data;
    logic [3:0]  be;
    logic [31:0] exp;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{3'd2, 3'd0, 32'h0000_8001, 4'h0, 32'h0, "R1 "},
    '{3'd1, 3'd3, 32'h0,         4'h0, 32'h0000_8001, "R1 "},
    '{3'd0, 3'd3, 32'h0000_0001, 4'h3, 32'h0, "R2 "},
    '{3'd1, 3'd3, 32'h0,         4'h0, 32'h0000_8000, "R2 "},
    '{3'd0, 3'd3, 32'h0000_FFFF, 4'h1, 32'h0, "R2 "},
    '{3'd1, 3'd3, 32'h0,         4'h0, 32'h0000_8000, "R2 "},
    '{3'd1, 3'd5, 32'h0,         4'h0, 32'h0000_0080, "R4 "},
    '{3'd0, 3'd3, 32'h0000_8000, 4'h3, 32'h0, "R2 "},
    '{3'd1, 3'd5, 32'h0,         4'h0, 32'h0000_0000, "R4 "},
    '{3'd0, 3'd1, 32'h0000_FFFF, 4'h3, 32'h0, "R8 "},
    '{3'd1, 3'd1, 32'h0,         4'h0, 32'h0000_0521, "R8 "},
    '{3'd0, 3'd4, 32'h0000_FFFF, 4'h2, 32'h0, "R8 "},
    '{3'd1, 3'd4, 32'h0,         4'h0, 32'h0000_0F00, "R8 "},
    '{3'd0, 3'd2, 32'h0000_1234, 4'h1, 32'h0, "R8 "},
    '{3'd1, 3'd2, 32'h0,         4'h0, 32'h0000_0034, "R8 "},
    '{3'd0, 3'd6, 32'hFFFF_FF00, 4'h1, 32'h0, "R6 "},
    '{3'd1, 3'd6, 32'h0,         4'h0, 32'h0000_00FF, "R6 "},
    '{3'd1, 3'd5, 32'h0,         4'h0, 32'h0000_0010, "R4 "},
    '{3'd0, 3'd6, 32'hFFFF_FFFF, 4'hF, 32'h0, "R6 "},
    '{3'd1, 3'd6, 32'h0,         4'h0, 32'h0000_0000, "R6 "},
    '{3'd1, 3'd7, 32'h0,         4'h0, 32'h0000_0000, "R11"},
    '{3'd3, 3'd0, 32'h0000_0001, 4'h0, 32'h0, "R4 "},
    '{3'd1, 3'd5, 32'h0,         4'h0, 32'h0000_0000, "R4 "},
    '{3'd3, 3'd0, 32'h0000_0100, 4'h0, 32'h0, "R4 "},
    '{3'd1, 3'd5, 32'h0,         4'h0, 32'h0000_0040, "R4 "},
    '{3'd0, 3'd0, 32'h0000_0101, 4'h3, 32'h0, "R2 "},
    '{3'd1, 3'd0, 32'h0,         4'h0, 32'h0000_0000, "R2 "},
    '{3'd4, 3'd0, 32'h0000_FFFF, 4'h0, 32'h0, "R3 "},
    '{3'd0, 3'd5, 32'h0000_FFFF, 4'h3, 32'h0, "R3 "},
    '{3'd1, 3'd5, 32'h0,         4'h0, 32'h0000_F2DA, "R3 "}
  };

  logic               clk = 1'b0;
  logic               rst;
  logic [NUM_EVT-1:0] evt_i;
  logic [REG_W-1:0]   pm_evt_i, glb_evt_i;
  logic               wr_en;
  logic [2:0]         wr_sel, rd_sel;
  logic [DEV_W-1:0]   wr_data;
  logic [DEV_W/8-1:0] wr_be;
  logic [DEV_W-1:0]   rd_data;
  logic               mode_req, mode_on;
  logic               irq_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pmev_aggregator #(.NUM_EVT(NUM_EVT), .REG_W(REG_W), .DEV_W(DEV_W)) u0 (
    .clk(clk), .rst(rst), .evt_i(evt_i), .pm_evt_i(pm_evt_i),
    .glb_evt_i(glb_evt_i), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .wr_be(wr_be), .rd_sel(rd_sel), .rd_data(rd_data),
    .mode_req(mode_req), .mode_on(mode_on), .irq_o(irq_o));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; evt_i = '0; pm_evt_i = '0; glb_evt_i = '0; mode_req = 0;
  endtask

  task automatic do_wr(input logic [2:0] sel, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d; wr_be = be;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic do_rd(input logic [2:0] sel, input logic [31:0] exp, input string req);
    @(negedge clk);
    rd_sel = sel;
    @(posedge clk); #1;
    check(req, rd_data, exp);
  endtask

  task automatic pulse(input logic [2:0] op, input logic [15:0] d);
    @(negedge clk);
    if (op == 3'd2) evt_i = d;
    else if (op == 3'd3) pm_evt_i = d;
    else glb_evt_i = d;
    @(posedge clk); #1;
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(); rd_sel = 3'd0; wr_sel = 3'd0; wr_data = '0; wr_be = '0; mode_on = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    check("R10", {31'b0, irq_o}, 32'h0);
    check("R10", rd_data, 32'h0);
    @(negedge clk); rst = 0;
    do_rd(3'd5, 32'h0, "R10");
    do_rd(3'd3, 32'h0, "R10");

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        3'd0: do_wr(VEC[i].sel, VEC[i].data, VEC[i].be);
        3'd1: do_rd(VEC[i].sel, VEC[i].exp, $sformatf("%s", VEC[i].tag));
        default: pulse(VEC[i].op, VEC[i].data[15:0]);
      endcase
    end

    // R5: gp pair alone (resume enable 0x0521, gp enable 0x0F00, pm 0)
    check("R5", {31'b0, irq_o}, 32'h0);
    pulse(3'd2, 16'h0200);
    check("R5", {31'b0, irq_o}, 32'h1);
    do_wr(3'd3, 32'h0200, 4'h3);
    check("R5", {31'b0, irq_o}, 32'h0);
    // R5: pm pair alone
    pulse(3'd3, 16'h0004);
    check("R5", {31'b0, irq_o}, 32'h1);
    do_wr(3'd0, 32'h0004, 4'h3);
    check("R5", {31'b0, irq_o}, 32'h0);
    // R5: pm event with resume enable cleared stays low
    do_wr(3'd1, 32'h0, 4'h3);
    pulse(3'd3, 16'h0020);
    check("R5", {31'b0, irq_o}, 32'h0);
    do_wr(3'd0, 32'h0020, 4'h3);

    // R9: event and clear of bit 3 in the same cycle
    @(negedge clk);
    evt_i = 16'h0008; wr_en = 1; wr_sel = 3'd3; wr_data = 32'h0008; wr_be = 4'h3;
    @(posedge clk); #1;
    idle();
    do_rd(3'd3, 32'h0000_0008, "R9");
    do_wr(3'd3, 32'h0008, 4'h3);

    // R7: mode on beats a write of zero to control
    @(negedge clk);
    mode_req = 1; mode_on = 1; wr_en = 1; wr_sel = 3'd2; wr_data = 32'h0; wr_be = 4'h3;
    @(posedge clk); #1;
    idle();
    do_rd(3'd2, 32'h0000_0001, "R7");
    do_rd(3'd1, 32'h0000_0001, "R7");
    @(negedge clk);
    mode_req = 1; mode_on = 0;
    @(posedge clk); #1;
    idle();
    do_rd(3'd2, 32'h0000_0000, "R7");
    do_rd(3'd1, 32'h0000_0000, "R7");

    // R10: reset mid-run
    do_wr(3'd1, 32'h0001, 4'h3);
    pulse(3'd3, 16'h0002);
    check("R10", {31'b0, irq_o}, 32'h1);
    @(negedge clk); rst = 1;
    @(posedge clk); #1;
    check("R10", {31'b0, irq_o}, 32'h0);
    @(negedge clk); rst = 0;
    do_rd(3'd0, 32'h0, "R10");
    do_rd(3'd1, 32'h0, "R10");
    do_rd(3'd5, 32'h0000_0000, "R10");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule